// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable model of a small serial EEPROM as it appears on a two-wire bus. The bus clock and data lines are oversampled by the system clock. A sampler finds clock edges, start conditions and stop conditions. A protocol sequencer decodes a device address byte against three strap inputs. It accepts a word address and up to a page of data bytes, and it streams stored bytes back on reads. The block drives only an open-drain pull-down enable, and the integrator resolves the wired line outside.

A write is held in a page-sized buffer. It is committed to the register-array memory only when the master closes the transfer with a stop placed exactly in the clock that follows an acknowledge. A timed commit then runs for a parameterized number of system clocks. During that commit the slave takes no part in the bus, so a master can poll with address bytes until it sees an acknowledge again. A power-on release input keeps the slave silent until it is asserted. A 128-byte build discards the top bit of the word address.

Top module: `eep_2w_slave`

## Requirements
- R1: A byte whose upper seven bits equal binary 1010 followed by the three strap bits is acknowledged by pulling SDA low during the ninth clock. The eighth bit selects the direction: 0 for write, 1 for read. Any other address byte gets no acknowledge.
- R2: While `por_done` is low the slave acknowledges nothing and never drives SDA.
- R3: A write transaction is a write address byte, then a word address byte, then 1 to 8 data bytes. Each data byte is acknowledged, and the bytes are stored when a stop arrives in the clock right after a data acknowledge. Successive data bytes go to successive addresses within the aligned 8-byte page: only the low three address bits advance, so a ninth position wraps to the page start.
- R4: A stop at any other position leaves memory unchanged and starts no commit. This includes a stop in the middle of a data byte and a stop right after the word address. In both cases the slave acknowledges its address again at once.
- R5: For `WR_CYCLES` system clocks after a committing stop, the slave gives no acknowledge, even to its own address. Afterwards, a write address byte is acknowledged again.
- R6: A read returns the byte at the current address, MSB first. Each bit is changed only while SCL is low, after a falling edge. The address advances by one over the whole memory after each byte. The read continues while the master acknowledges and ends on a master not-acknowledge. A later read continues from the following address.
- R7: A repeated start after the word address byte sets the current address without writing anything.
- R8: With `MEM_BYTES` = 128, bit 7 of the word address is ignored.
- R9: After reset, `sda_oe` is low.
- R10: `sda_oe` only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_done | input | 1 | Power-on release; the slave ignores the bus while low |
| strap | input | 3 | Device select straps (tie unused straps to 0) |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the resolved wire |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
Two functions can fall in the same cycle: the stop detector and the write-slot position check. That cycle decides between starting the commit and discarding the page buffer. The bench provokes it three ways: a stop one clock after a data acknowledge, a stop three bits into a data byte, and a stop after only the word address. It judges each case at the ports, by whether an immediate address poll is refused and by what a later read returns. A second slave with a 128-byte array shares the same bus, so the bench also confirms that two devices with different straps never answer together.

// File: rtl/eep_pkg.sv
package eep_pkg;

  // fixed upper nibble of the device address byte
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start condition
    ST_DEV,    // shifting in the device address byte
    ST_ADDR,   // shifting in the word address byte
    ST_WDATA,  // shifting in write data bytes
    ST_ACK,    // slave acknowledge clock
    ST_RDATA,  // shifting out a read byte
    ST_RACK    // master acknowledged, next byte pending
  } bus_st_e;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] scl_pipe_q, sda_pipe_q;
  logic            scl_now, scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-1:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_now = scl_pipe_q[STAGES-1];
  assign scl_old = scl_pipe_q[STAGES];
  assign sda_s   = sda_pipe_q[STAGES-1];
  assign sda_old = sda_pipe_q[STAGES];

  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;

endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 2000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          buf_we,
  input  logic                          buf_clr,
  input  logic [$clog2(PAGE_BYTES)-1:0] buf_idx,
  input  logic [7:0]                    buf_data,
  input  logic                          commit,
  input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] page_tag,
  input  logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
  output logic [7:0]                    rd_data,
  output logic                          busy
);

  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [7:0]            mem  [MEM_BYTES];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pval_q, pval_d;
  logic [CW-1:0]         tmr_q, tmr_d;

  // per-slot valid flags of the page buffer
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    assign pval_d[g] = (buf_clr || commit)               ? 1'b0 :
                       (buf_we && buf_idx == PW'(g))     ? 1'b1 : pval_q[g];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (buf_we && buf_idx == PW'(i)) pbuf[i] <= buf_data;
    end
  end

  // commit: every valid slot lands in the addressed page at once
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pval_q[i]) mem[{page_tag, PW'(i)}] <= pbuf[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];

  always_comb begin
    tmr_d = tmr_q;
    if (commit)            tmr_d = CW'(WR_CYCLES);
    else if (tmr_q != '0)  tmr_d = tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pval_q <= '0;
      tmr_q  <= '0;
    end else begin
      pval_q <= pval_d;
      tmr_q  <= tmr_d;
    end
  end

  assign busy = (tmr_q != '0);

endmodule

// File: rtl/eep_2w_slave.sv
module eep_2w_slave
  import eep_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_done,
  input  logic [2:0] strap,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam logic [PW:0] CNT_FULL = (PW+1)'(PAGE_BYTES);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  bus_st_e        st_q, st_d, nxt_q, nxt_d;
  logic [3:0]     bcnt_q, bcnt_d;
  logic [7:0]     sh_q, sh_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [PW:0]    wcnt_q, wcnt_d;
  logic           oe_q, oe_d;
  logic           buf_we, buf_clr, commit, wr_busy;
  logic [7:0]     rd_data;

  eep_mem #(
    .MEM_BYTES  (MEM_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
  ) u_mem (
    .clk      (clk),
    .rst_n    (rst_ni),
    .buf_we   (buf_we),
    .buf_clr  (buf_clr),
    .buf_idx  (addr_q[PW-1:0]),
    .buf_data (sh_q),
    .commit   (commit),
    .page_tag (addr_q[AW-1:PW]),
    .rd_addr  (addr_q),
    .rd_data  (rd_data),
    .busy     (wr_busy)
  );

  always_comb begin
    st_d    = st_q;
    nxt_d   = nxt_q;
    bcnt_d  = bcnt_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    wcnt_d  = wcnt_q;
    oe_d    = oe_q;
    buf_we  = 1'b0;
    buf_clr = 1'b0;
    commit  = 1'b0;

    if (!por_done || wr_busy) begin
      // bus ignored entirely
      st_d    = ST_IDLE;
      oe_d    = 1'b0;
      bcnt_d  = '0;
      buf_clr = ~por_done;
    end else if (stop_det) begin
      st_d   = ST_IDLE;
      oe_d   = 1'b0;
      bcnt_d = '0;
      // only the first clock after a data acknowledge commits
      if (st_q == ST_WDATA && bcnt_q == 4'd1 && wcnt_q != '0) commit  = 1'b1;
      else                                                    buf_clr = 1'b1;
    end else if (start_det) begin
      st_d    = ST_DEV;
      oe_d    = 1'b0;
      bcnt_d  = '0;
      wcnt_d  = '0;
      buf_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (scl_rise && bcnt_q != 4'd8) begin
            sh_d   = {sh_q[6:0], sda_s};
            bcnt_d = bcnt_q + 4'd1;
          end else if (scl_fall && bcnt_q == 4'd8) begin
            st_d   = ST_ACK;
            oe_d   = 1'b1;
            bcnt_d = '0;
            nxt_d  = ST_WDATA;
            if (st_q == ST_DEV) begin
              if (sh_q[7:1] == {DEV_TYPE, strap}) begin
                nxt_d = sh_q[0] ? ST_RDATA : ST_ADDR;
              end else begin
                st_d = ST_IDLE;
                oe_d = 1'b0;
              end
            end else if (st_q == ST_ADDR) begin
              addr_d  = sh_q[AW-1:0];
              wcnt_d  = '0;
              buf_clr = 1'b1;
            end else begin
              buf_we = 1'b1;
              addr_d = {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
              if (wcnt_q != CNT_FULL) wcnt_d = wcnt_q + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st_d   = nxt_q;
            bcnt_d = '0;
            if (nxt_q == ST_RDATA) begin
              sh_d   = rd_data;
              oe_d   = ~rd_data[7];
              addr_d = addr_q + 1'b1;
            end else begin
              oe_d = 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (bcnt_q < 4'd7) begin
              sh_d   = {sh_q[6:0], 1'b0};
              oe_d   = ~sh_q[6];
              bcnt_d = bcnt_q + 4'd1;
            end else if (bcnt_q == 4'd7) begin
              oe_d   = 1'b0;
              bcnt_d = 4'd8;
            end
          end else if (scl_rise && bcnt_q == 4'd8) begin
            st_d = sda_s ? ST_IDLE : ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            st_d   = ST_RDATA;
            bcnt_d = '0;
            sh_d   = rd_data;
            oe_d   = ~rd_data[7];
            addr_d = addr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      nxt_q  <= ST_IDLE;
      bcnt_q <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      wcnt_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      nxt_q  <= nxt_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      addr_q <= addr_d;
      wcnt_q <= wcnt_d;
      oe_q   <= oe_d;
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/eep_2w_slave_chk.sv
module eep_2w_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic por_done,
  input logic scl_i,
  input logic sda_oe,
  input logic busy,
  input logic stop_det
);

  // R2: held silent before power-on release
  a_r2_silent_before_por: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |=> !sda_oe);

  // R5: no drive of any kind while the commit runs
  a_r5_silent_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R3: a commit only ever follows a detected stop
  a_r3_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  // R10: pull-down only begins while the bus clock is low
  a_r10_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

endmodule

bind eep_2w_slave eep_2w_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .por_done (por_done),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .busy     (wr_busy),
  .stop_det (stop_det)
);

// File: tb/tb_eep_2w_slave.sv
module tb_eep_2w_slave;

  logic clk, rst_n, por_done, scl, m_sda;
  logic oe_a, oe_b, sda_line;
  int   checks, errors;

  localparam logic [2:0] SEL_A = 3'b101;  // 256-byte device
  localparam logic [2:0] SEL_B = 3'b010;  // 128-byte device

  assign sda_line = m_sda & ~oe_a & ~oe_b;

  eep_2w_slave dut (
    .clk(clk), .rst_n(rst_n), .por_done(por_done), .strap(SEL_A),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(oe_a)
  );

  eep_2w_slave #(.MEM_BYTES(128)) u_small (
    .clk(clk), .rst_n(rst_n), .por_done(por_done), .strap(SEL_B),
    .scl_i(scl), .sda_i(sda_line), .sda_oe(oe_b)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  typedef struct { logic [7:0] val; string req; } sb_t;
  sb_t        exp_q[$];
  logic [7:0] got_q[$];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_rd(input logic [7:0] v, input string req);
    sb_t it;
    it.val = v;
    it.req = req;
    exp_q.push_back(it);
  endtask

  // monitor: pops captured read bytes against the expected queue
  initial begin
    logic [7:0] g;
    sb_t        e;
    forever begin
      @(negedge clk);
      while (got_q.size() != 0) begin
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          check("R6 unexpected read byte", g, 'h100);
        end else begin
          e = exp_q.pop_front();
          check(e.req, g, e.val);
        end
      end
    end
  end

  // ---------------- bus master ----------------
  task automatic hp();
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic bstart();
    m_sda = 1'b1; hp(); scl = 1'b1; hp(); m_sda = 1'b0; hp(); scl = 1'b0; hp();
  endtask

  task automatic bstop();
    m_sda = 1'b0; hp(); scl = 1'b1; hp(); m_sda = 1'b1; hp();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; hp(); scl = 1'b1; hp();
    ack = !sda_line;
    scl = 1'b0;
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hp(); scl = 1'b1; hp();
      b = {b[6:0], sda_line};
      scl = 1'b0;
    end
    m_sda = mack ? 1'b0 : 1'b1;
    hp(); scl = 1'b1; hp(); scl = 1'b0;
    m_sda = 1'b1;
  endtask

  task automatic dev_cmd(input bit rd, input logic [2:0] sel, output bit ack);
    bstart();
    wr_byte({4'b1010, sel, rd}, ack);
  endtask

  task automatic page_write(input logic [2:0] sel, input logic [7:0] addr,
                            input logic [7:0] base, input int n);
    bit ack;
    dev_cmd(1'b0, sel, ack);
    check("R1 write address ack", ack, 1);
    wr_byte(addr, ack);
    check("R3 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wr_byte(base + 8'(i), ack);
      check("R3 data byte ack", ack, 1);
    end
    bstop();
  endtask

  task automatic wait_ready(input logic [2:0] sel);
    bit ack;
    int polls;
    polls = 0;
    do begin
      dev_cmd(1'b0, sel, ack);
      bstop();
      polls++;
    end while (!ack && polls < 100);
    check("R5 acknowledge returns after commit", ack, 1);
    check("R5 commit refused at least one poll", int'(polls > 1), 1);
  endtask

  task automatic set_addr(input logic [2:0] sel, input logic [7:0] addr);
    bit ack;
    dev_cmd(1'b0, sel, ack);
    check("R7 address phase ack", ack, 1);
    wr_byte(addr, ack);
    check("R7 word address ack", ack, 1);
  endtask

  task automatic read_seq(input logic [2:0] sel, input int n);
    bit         ack;
    logic [7:0] b;
    dev_cmd(1'b1, sel, ack);
    check("R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, b);
      got_q.push_back(b);
    end
    bstop();
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    checks = 0; errors = 0;
    rst_n = 1'b0; por_done = 1'b0; scl = 1'b1; m_sda = 1'b1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    check("R9 sda_oe low after reset", oe_a, 0);
    check("R9 small sda_oe low after reset", oe_b, 0);

    // R2: no response before power-on release
    dev_cmd(1'b0, SEL_A, ack);
    bstop();
    check("R2 no ack before por_done", ack, 0);
    por_done = 1'b1;
    hp();

    // R1: address matching
    dev_cmd(1'b0, 3'b000, ack);
    bstop();
    check("R1 foreign select not acked", ack, 0);
    dev_cmd(1'b0, SEL_A, ack);
    bstop();
    check("R1 own select acked", ack, 1);
    dev_cmd(1'b0, SEL_B, ack);
    bstop();
    check("R1 second device select acked", ack, 1);

    // R3 byte write, R5 polling
    page_write(SEL_A, 8'h10, 8'hA5, 1);
    dev_cmd(1'b0, SEL_A, ack);
    bstop();
    check("R5 own address refused during commit", ack, 0);
    wait_ready(SEL_A);

    // R7 dummy write then R6 read
    set_addr(SEL_A, 8'h10);
    expect_rd(8'hA5, "R7 read after address set");
    read_seq(SEL_A, 1);

    // R3 page writes with wrap inside the page
    page_write(SEL_A, 8'h18, 8'h30, 8);
    wait_ready(SEL_A);
    page_write(SEL_A, 8'h1C, 8'h50, 6);
    wait_ready(SEL_A);
    page_write(SEL_A, 8'h20, 8'h60, 2);
    wait_ready(SEL_A);

    set_addr(SEL_A, 8'h18);
    expect_rd(8'h54, "R3 wrapped byte at page start");
    expect_rd(8'h55, "R3 wrapped byte at page start+1");
    expect_rd(8'h32, "R3 untouched slot kept");
    expect_rd(8'h33, "R3 untouched slot kept");
    read_seq(SEL_A, 4);
    // R6: current-address read continues and crosses the page edge
    expect_rd(8'h50, "R6 continue after nack");
    expect_rd(8'h51, "R6 sequential");
    expect_rd(8'h52, "R6 sequential");
    expect_rd(8'h53, "R6 sequential");
    expect_rd(8'h60, "R6 crosses page boundary");
    expect_rd(8'h61, "R6 crosses page boundary");
    read_seq(SEL_A, 6);

    // R4: stops outside the commit slot
    page_write(SEL_A, 8'h40, 8'h77, 1);
    wait_ready(SEL_A);
    dev_cmd(1'b0, SEL_A, ack);
    wr_byte(8'h40, ack);
    wr_byte(8'h11, ack);
    check("R4 data byte acked before abort", ack, 1);
    send_bits(8'h22, 3);
    bstop();
    dev_cmd(1'b0, SEL_A, ack);
    bstop();
    check("R4 no commit after mid-byte stop", ack, 1);
    dev_cmd(1'b0, SEL_A, ack);
    wr_byte(8'h41, ack);
    bstop();
    dev_cmd(1'b0, SEL_A, ack);
    bstop();
    check("R4 no commit after address-only write", ack, 1);
    set_addr(SEL_A, 8'h40);
    expect_rd(8'h77, "R4 memory unchanged by aborted write");
    read_seq(SEL_A, 1);

    // R8: 128-byte device ignores the top word address bit
    page_write(SEL_B, 8'h85, 8'h3C, 1);
    wait_ready(SEL_B);
    set_addr(SEL_B, 8'h05);
    expect_rd(8'h3C, "R8 top address bit ignored");
    read_seq(SEL_B, 1);

    repeat (20) @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule